// File: doc/BRIEF.md
# Parallel attenuation state selector

This block settles the 7-bit control word of a step attenuator. The word is a binary count of quarter-decibel units, so a setting in dB times four gives the code and the all-ones code is the deepest attenuation. The word comes from one of two sources. With the source select low, seven parallel pins drive it, either transparently while the latch strobe is held high or captured when the strobe falls. With the select high, a serial front end supplies a ready-made word with a one-cycle valid pulse.

After reset, which stands in for power-up, the word sits at maximum attenuation. In transparent parallel mode the pins take effect only after a fixed power-up hold. Every change is spaced by a minimum interval. A change that arrives too early is parked, and the latest parked value is applied as soon as the interval has run out. Switching the source select never changes the word by itself: the word holds until the newly chosen source presents an update.

Top module: `atten_state_sel`

## Requirements
- R1: While reset is high, and after it until some source updates the word, `atten_state` is 127. In latched parallel mode (latch strobe low) and in serial mode it stays 127 however long the power-up hold lasts.
- R2: `atten_state` bit 6 weighs 16 dB and bit 0 weighs 0.25 dB, halving per bit. A code written as dB x 4 (for example 73 for 18.25 dB) appears unchanged on the output.
- R3: With select low and strobe high after the power-up hold, the word follows `par_bits`. A value presented before clock edge k appears after edge k+1, provided the spacing rule allows it.
- R4: With select low and strobe low, changes on `par_bits` have no effect. The cycle in which the strobe is first seen low after being high captures `par_bits` of that cycle.
- R5: With select high, `par_bits` and `latch_en` have no effect. `ser_state` is taken in the cycle where `ser_valid` is high and reaches the output one edge later.
- R6: With select low and strobe high from reset release, the output stays 127 through edge PUP+1 after release and shows the pin preset from edge PUP+2. PUP is CLK_MHZ x PUP_US cycles.
- R7: Two successive output changes are at least GAP = CLK_MHZ x GAP_US edges apart. A request made inside the interval is deferred, and the most recent one is applied exactly at the edge where the interval ends.
- R8: A change of the source select leaves the output unchanged and drops any deferred request. The output moves only on a fresh update from the newly selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| par_bits | input | 7 | Parallel attenuation code, quarter-dB units |
| latch_en | input | 1 | High: transparent; falling: capture |
| ser_sel | input | 1 | Source select: 0 parallel, 1 serial |
| ser_state | input | 7 | Word delivered by the serial front end |
| ser_valid | input | 1 | One-cycle strobe qualifying `ser_state` |
| atten_state | output | 7 | Registered attenuator control word |

## Verification
An accepted request is registered on the first edge and applied on the second. So a pin, strobe or serial update driven before edge k is due on the output after edge k+1. When the spacing interval is still running, the update is due exactly GAP edges after the previous change. The power-up preset is due at edge PUP+2 after reset release. The bench keeps a cycle counter and enqueues every expectation with its absolute due cycle at the moment the stimulus is driven. The monitor compares only in that cycle, one edge before it for the "not yet" side, and at later cycles for the "no effect" cases.

// File: rtl/atten_pkg.sv
package atten_pkg;

  typedef enum logic {
    SRC_PARALLEL = 1'b0,
    SRC_SERIAL   = 1'b1
  } src_e;

  function automatic int unsigned us_to_cycles(input int unsigned mhz,
                                               input int unsigned us);
    return mhz * us;
  endfunction

endpackage

// File: rtl/atten_pup_timer.sv
module atten_pup_timer #(
  parameter int unsigned HOLD_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LAST);

  // R6: once the hold has expired it stays expired until reset
  assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $past(done) |-> done);

endmodule

// File: rtl/atten_src_arb.sv
module atten_src_arb
  import atten_pkg::*;
#(
  parameter int unsigned STATE_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] par_bits,
  input  logic               latch_en,
  input  logic               ser_sel,
  input  logic [STATE_W-1:0] ser_state,
  input  logic               ser_valid,
  input  logic               pup_done,
  output logic               req_vld,
  output logic [STATE_W-1:0] req_code,
  output logic               flush
);
  src_e sel_now;
  src_e sel_q;
  logic le_q;
  logic le_fall;

  assign sel_now = ser_sel ? SRC_SERIAL : SRC_PARALLEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q  <= 1'b0;
      sel_q <= sel_now;
    end else begin
      le_q  <= latch_en;
      sel_q <= sel_now;
    end
  end

  assign le_fall = le_q & ~latch_en;
  assign flush   = (sel_now != sel_q);

  always_comb begin
    req_vld  = 1'b0;
    req_code = par_bits;
    if (sel_now == SRC_SERIAL) begin
      req_vld  = ser_valid;
      req_code = ser_state;
    end else if (latch_en && pup_done) begin
      req_vld  = 1'b1;
    end else if (le_fall) begin
      req_vld  = 1'b1;
    end
  end

  // R4: a parallel request with the strobe low must follow a strobe high cycle
  assert_latch_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !ser_sel && !latch_en) |-> $past(latch_en));

endmodule

// File: rtl/atten_rate_gate.sv
module atten_rate_gate #(
  parameter int unsigned STATE_W = 7,
  parameter int unsigned GAP_CYC = 10000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_vld,
  input  logic [STATE_W-1:0] req_code,
  input  logic               flush,
  output logic [STATE_W-1:0] state
);
  localparam int unsigned GW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [GW-1:0] LAST = GW'(GAP_CYC - 1);
  localparam logic [STATE_W-1:0] MAX_CODE = {STATE_W{1'b1}};

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] want_q;
  logic               want_vld_q;
  logic [GW-1:0]      gap_q;
  logic               ready;

  assign ready = (gap_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= MAX_CODE;
      want_q     <= '0;
      want_vld_q <= 1'b0;
      gap_q      <= LAST;
    end else begin
      if (!ready) begin
        gap_q <= gap_q + 1'b1;
      end
      if (want_vld_q && ready) begin
        if (want_q != state_q) begin
          state_q <= want_q;
          gap_q   <= '0;
        end
        want_vld_q <= 1'b0;
      end
      if (req_vld) begin
        want_q     <= req_code;
        want_vld_q <= 1'b1;
      end else if (flush) begin
        want_vld_q <= 1'b0;
      end
    end
  end

  assign state = state_q;

  // R1: reset forces maximum attenuation
  assert_reset_max_R1: assert property (@(posedge clk)
    rst |=> (state_q == MAX_CODE));

  // R7: a change only when the spacing interval has fully elapsed
  assert_min_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |-> ($past(gap_q) == LAST));

  // R7: a change always lands on the parked request
  assert_apply_parked_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q != $past(state_q)) |-> ($past(want_vld_q) && state_q == $past(want_q)));

  // R8: a source switch without a new request drops the parked one
  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && !req_vld) |=> !want_vld_q);

endmodule

// File: rtl/atten_state_sel.sv
module atten_state_sel
  import atten_pkg::*;
#(
  parameter int unsigned STATE_W = 7,
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned PUP_US  = 400,
  parameter int unsigned GAP_US  = 40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] par_bits,
  input  logic               latch_en,
  input  logic               ser_sel,
  input  logic [STATE_W-1:0] ser_state,
  input  logic               ser_valid,
  output logic [STATE_W-1:0] atten_state
);
  localparam int unsigned PUP_CYC = us_to_cycles(CLK_MHZ, PUP_US);
  localparam int unsigned GAP_CYC = us_to_cycles(CLK_MHZ, GAP_US);

  logic               pup_done;
  logic               req_vld;
  logic [STATE_W-1:0] req_code;
  logic               flush;

  atten_pup_timer #(
    .HOLD_CYC(PUP_CYC)
  ) i_pup (
    .clk  (clk),
    .rst  (rst),
    .done (pup_done)
  );

  atten_src_arb #(
    .STATE_W(STATE_W)
  ) i_arb (
    .clk       (clk),
    .rst       (rst),
    .par_bits  (par_bits),
    .latch_en  (latch_en),
    .ser_sel   (ser_sel),
    .ser_state (ser_state),
    .ser_valid (ser_valid),
    .pup_done  (pup_done),
    .req_vld   (req_vld),
    .req_code  (req_code),
    .flush     (flush)
  );

  atten_rate_gate #(
    .STATE_W(STATE_W),
    .GAP_CYC(GAP_CYC)
  ) i_gate (
    .clk      (clk),
    .rst      (rst),
    .req_vld  (req_vld),
    .req_code (req_code),
    .flush    (flush),
    .state    (atten_state)
  );

  // R5: in serial mode no request is raised without the serial strobe
  assert_serial_gated_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_sel && req_vld) |-> ser_valid);

endmodule

// File: tb/test_atten_state_sel.sv
module test_atten_state_sel;
  localparam int PUP = 400;
  localparam int GAP = 40;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] par_bits;
  logic       latch_en;
  logic       ser_sel;
  logic [6:0] ser_state;
  logic       ser_valid;
  logic [6:0] atten_state;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int         due_q[$];
  logic [6:0] val_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  // design scaled to 1 cycle per microsecond: PUP=400, GAP=40 cycles
  atten_state_sel #(.STATE_W(7), .CLK_MHZ(1), .PUP_US(400), .GAP_US(40)) i_atten_state_sel (
    .clk(clk), .rst(rst), .par_bits(par_bits), .latch_en(latch_en),
    .ser_sel(ser_sel), .ser_state(ser_state), .ser_valid(ser_valid),
    .atten_state(atten_state)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int due, input logic [6:0] v, input string tag);
    due_q.push_back(due);
    val_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops expectations in their due cycle
  always @(negedge clk) begin
    if (!done) begin
      while (due_q.size() > 0 && due_q[0] <= cyc) begin
        checks++;
        if (due_q[0] != cyc) begin
          errors++;
          $display("FAIL %s: check missed at cycle %0d (due %0d)", tag_q[0], cyc, due_q[0]);
        end else if (atten_state !== val_q[0]) begin
          errors++;
          $display("FAIL %s: cycle %0d actual=%0d expected=%0d",
                   tag_q[0], cyc, atten_state, val_q[0]);
        end
        void'(due_q.pop_front());
        void'(val_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (cyc > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: run hung at cycle %0d actual=%0d expected=finished", cyc, atten_state);
        done = 1'b1;
        finish_run();
      end
    end
  end

  initial begin
    int t;
    int last;
    rst = 1'b1; ser_sel = 1'b0; latch_en = 1'b1; par_bits = 7'd45;
    ser_state = '0; ser_valid = 1'b0;
    step(3);
    expect_at(cyc + 1, 7'd127, "R1");
    step(2);
    // R6: direct preset 45 held off by the power-up interval
    rst = 1'b0; t = cyc;
    expect_at(t + 200, 7'd127, "R1");
    expect_at(t + PUP + 1, 7'd127, "R6");
    expect_at(t + PUP + 2, 7'd45, "R6");
    step(PUP + 45);

    // R2/R3: 18.25 dB -> code 73, direct path latency two edges
    par_bits = 7'd73; t = cyc;
    expect_at(t + 1, 7'd45, "R3");
    expect_at(t + 2, 7'd73, "R2");
    last = t + 2;
    step(3);

    // R7: early requests parked, latest wins at interval end
    par_bits = 7'd10;
    step(5);
    par_bits = 7'd20;
    expect_at(last + GAP - 1, 7'd73, "R7");
    expect_at(last + GAP, 7'd20, "R7");
    step(GAP + 5);

    // R4: strobe low, pin changes ignored
    latch_en = 1'b0;
    step(GAP + 5);
    par_bits = 7'd99; t = cyc;
    expect_at(t + 2, 7'd20, "R4");
    expect_at(t + 10, 7'd20, "R4");
    step(12);
    latch_en = 1'b1; t = cyc;
    expect_at(t + 2, 7'd99, "R3");
    step(1);
    latch_en = 1'b0; par_bits = 7'd55;
    expect_at(t + 2 + GAP - 1, 7'd99, "R7");
    expect_at(t + 2 + GAP, 7'd55, "R4");
    step(GAP + 6);

    // R5: serial mode ignores pins and strobe
    ser_sel = 1'b1; par_bits = 7'd3;
    step(2);
    latch_en = 1'b1;
    step(2);
    latch_en = 1'b0; par_bits = 7'd5; t = cyc;
    expect_at(t + 3, 7'd55, "R5");
    expect_at(t + GAP + 5, 7'd55, "R5");
    step(GAP + 8);
    ser_state = 7'd100; ser_valid = 1'b1; t = cyc;
    expect_at(t + 1, 7'd55, "R5");
    expect_at(t + 2, 7'd100, "R5");
    step(1);
    ser_valid = 1'b0;
    step(GAP + 5);

    // R8: switch back to parallel holds until a parallel update
    ser_sel = 1'b0; par_bits = 7'd12; t = cyc;
    expect_at(t + 3, 7'd100, "R8");
    expect_at(t + GAP, 7'd100, "R8");
    step(GAP + 3);
    latch_en = 1'b1; t = cyc;
    expect_at(t + 2, 7'd12, "R8");
    step(1);
    latch_en = 1'b0;
    step(5);

    // R1: reset in latched mode stays at maximum past the hold
    rst = 1'b1; t = cyc;
    expect_at(t + 1, 7'd127, "R1");
    step(2);
    rst = 1'b0; t = cyc;
    expect_at(t + PUP + 10, 7'd127, "R1");
    step(PUP + 12);

    step(3);
    done = 1'b1;
    if (due_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL queue: actual=%0d pending expected=0", due_q.size());
    end
    finish_run();
  end

endmodule